// File: doc/BRIEF.md
# Serial Register Front End for a Power-Management Device

This block is the serial slave side of a power-management device. A host reaches a bank of 24-bit registers over a four-wire serial link in clock mode 0, with an active-low select. Every access is one 32-bit frame. The top bit chooses between write (1) and read (0). The next six bits name the register. The low 24 bits carry the write data. A read returns the register contents inside the same frame. The host may stream any number of frames, each aimed at any register, while select stays low.

Most of the register space is plain storage. A few addresses carry behaviour:
- Address 0 and address 2 are event status registers. Writing a one to a bit clears that bit.
- Address 1 and address 3 are their masks. Each mask resets to all ones.
- Address 4 is a read-only sense register. It shows the live level of two active-low inputs: a power button and an accessory detect.

Every change of level on either input latches an event in the status register at address 2. The single interrupt line stays high while any status bit is unmasked.

Top module: `pmic_spi_regs`

## Requirements
- R1: Frame bit 31 selects write (1) or read (0). Bits 30:25 give the register address. Bits 23:0 give the data. Bit 24 is ignored.
- R2: During every frame the slave drives MISO MSB-first. It changes MISO after each falling SCLK so the host can sample it on the rising edge. Bits 31:24 are returned as zero, and bits 23:0 hold the contents of the addressed register.
- R3: Any number of frames may follow one another under a single low select. Each frame is executed independently of the others.
- R4: An address at or above the NUM_REGS parameter is rejected: a write there changes nothing, and a read returns zero.
- R5: Storage registers (every address other than 0 to 4) reset to zero and return the last 24-bit value written.
- R6: The mask registers at addresses 1 and 3 reset to 0xFFFFFF. While both hold all ones, the interrupt output is low whatever the status bits hold.
- R7: The status registers at addresses 0 and 2 reset to zero. A write clears each bit written as one and leaves each bit written as zero unchanged. A new event in the same cycle wins over a clear. Address 0 has no event source.
- R8: The sense register at address 4 shows the power-button level in bit 0 and the accessory-detect level in bit 1. The upper bits read zero. The register reads 0 in a bit whose input is active (low). Writes to it are ignored.
- R9: Every change of level on the power-button input sets status bit 0 at address 2. Every change on the accessory-detect input sets status bit 1. Both inputs pass through a two-flop synchronizer before edge detection.
- R10: The interrupt output is high exactly when some status bit at address 0 or 2 is set while the matching mask bit is zero.
- R11: A frame is discarded with no register change if select rises before its 32nd bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all serial lines are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idle low |
| spi_cs_n | input | 1 | Active-low select framing a transaction |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| pwr_btn_n | input | 1 | Power-button input, active low |
| acc_det_n | input | 1 | Accessory-detect input, active low |
| irq | output | 1 | High while an unmasked status event is pending |

## Verification
The assertions check the following on every cycle:
- A sense edge always lands in the status register, even against a clearing write in the same cycle.
- A write-one-to-clear leaves none of the written bits set.
- Status contents change only through frames or events.
- All-ones masks keep the interrupt low.
- Read frames and rejected addresses leave the masks alone.

The bench's scenarios show the rest:
- The value that actually returns on MISO in the same frame.
- A sweep that streams a write to every address and then a read of every address.
- The dropping of a frame cut short by select.
- Sense levels and the interrupt responding to the button and detect inputs.

// File: rtl/pmic_pkg.sv
package pmic_pkg;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 24;
  localparam int ADDR_W  = 6;

  localparam logic [ADDR_W-1:0] A_STAT0 = 6'd0;
  localparam logic [ADDR_W-1:0] A_MASK0 = 6'd1;
  localparam logic [ADDR_W-1:0] A_STAT1 = 6'd2;
  localparam logic [ADDR_W-1:0] A_MASK1 = 6'd3;
  localparam logic [ADDR_W-1:0] A_SENSE = 6'd4;

  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  function automatic logic fr_is_write(input logic [FRAME_W-1:0] w);
    return w[31];
  endfunction

  function automatic logic [ADDR_W-1:0] fr_addr(input logic [FRAME_W-1:0] w);
    return w[30:25];
  endfunction

  function automatic logic [DATA_W-1:0] fr_data(input logic [FRAME_W-1:0] w);
    return w[23:0];
  endfunction

  // clear-by-one, with new events taking precedence
  function automatic logic [DATA_W-1:0] w1c_next(input logic [DATA_W-1:0] old,
                                                 input logic clr_en,
                                                 input logic [DATA_W-1:0] ones,
                                                 input logic [DATA_W-1:0] set);
    logic [DATA_W-1:0] kept;
    kept = clr_en ? (old & ~ones) : old;
    return kept | set;
  endfunction

  function automatic logic pending(input logic [DATA_W-1:0] stat,
                                   input logic [DATA_W-1:0] mask);
    return |(stat & ~mask);
  endfunction

  // bit driven for the next host sample, given bits already received
  function automatic logic rd_bit(input logic [DATA_W-1:0] d, input logic [4:0] cnt);
    logic [4:0] idx;
    if (cnt < 5'd8) return 1'b0;
    idx = 5'd31 - cnt;
    return d[idx];
  endfunction
endpackage

// File: rtl/pmic_sync.sv
module pmic_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) st[k] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int k = 1; k < STAGES; k++) st[k] <= st[k-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/pmic_sense.sv
module pmic_sense #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_n,
  output logic [N-1:0] lvl,
  output logic [N-1:0] evt
);
  logic [N-1:0] lvl_d;

  pmic_sync #(.W(N), .STAGES(2), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_n), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_d <= '1;
    else        lvl_d <= lvl;
  end

  assign evt = lvl ^ lvl_d;
endmodule

// File: rtl/pmic_spi_frame.sv
module pmic_spi_frame
  import pmic_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sclk_s,
  input  logic                cs_n_s,
  input  logic                mosi_s,
  input  logic [DATA_W-1:0]   rd_data,
  output logic [ADDR_W-1:0]   rd_addr,
  output logic                frame_done,
  output logic [FRAME_W-1:0]  frame_word,
  output logic                miso
);
  logic              sclk_d;
  logic              sclk_rise;
  logic              sclk_fall;
  logic [4:0]        cnt;
  logic [30:0]       shreg;
  logic [DATA_W-1:0] rd_hold;
  logic              miso_q;
  logic              done_q;
  logic [FRAME_W-1:0] word_q;

  assign sclk_rise = sclk_s & ~sclk_d & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_d & ~cs_n_s;
  // address is complete on the 7th rising edge: take the incoming bit directly
  assign rd_addr   = {shreg[4:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      shreg   <= '0;
      rd_hold <= '0;
      miso_q  <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (cs_n_s) begin
        cnt    <= '0;
        miso_q <= 1'b0;
      end else if (sclk_rise) begin
        shreg <= {shreg[29:0], mosi_s};
        cnt   <= cnt + 5'd1;
        if (cnt == 5'd6) rd_hold <= rd_data;
        if (cnt == 5'd31) begin
          done_q <= 1'b1;
          word_q <= {shreg, mosi_s};
        end
      end else if (sclk_fall) begin
        miso_q <= rd_bit(rd_hold, cnt);
      end
    end
  end

  assign frame_done = done_q;
  assign frame_word = word_q;
  assign miso       = miso_q;
endmodule

// File: rtl/pmic_regbank.sv
module pmic_regbank
  import pmic_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [1:0]        sense_lvl,
  input  logic [1:0]        sense_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] stat0,
  output logic [DATA_W-1:0] stat1,
  output logic [DATA_W-1:0] mask0,
  output logic [DATA_W-1:0] mask1,
  output logic              irq
);
  localparam logic [ADDR_W:0] NREG = (ADDR_W+1)'(NUM_REGS);

  logic [DATA_W-1:0] rd_vec [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic hit;
    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    if (i == int'(A_STAT0) || i == int'(A_STAT1)) begin : g_stat
      logic [DATA_W-1:0] q;
      logic [DATA_W-1:0] set;
      assign set = (i == int'(A_STAT1)) ? {{(DATA_W-2){1'b0}}, sense_evt} : '0;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= w1c_next(q, hit, wr_data, set);
      end
      assign rd_vec[i] = q;
    end else if (i == int'(A_MASK0) || i == int'(A_MASK1)) begin : g_mask
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= ALL_ONES;
        else if (hit) q <= wr_data;
      end
      assign rd_vec[i] = q;
    end else if (i == int'(A_SENSE)) begin : g_sense
      assign rd_vec[i] = {{(DATA_W-2){1'b0}}, sense_lvl};
    end else begin : g_plain
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= wr_data;
      end
      assign rd_vec[i] = q;
    end
  end

  assign rd_data = ({1'b0, rd_addr} < NREG) ? rd_vec[rd_addr] : '0;
  assign stat0   = rd_vec[A_STAT0];
  assign stat1   = rd_vec[A_STAT1];
  assign mask0   = rd_vec[A_MASK0];
  assign mask1   = rd_vec[A_MASK1];
  assign irq     = pending(stat0, mask0) | pending(stat1, mask1);
endmodule

// File: rtl/pmic_spi_regs.sv
module pmic_spi_regs
  import pmic_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic spi_sclk,
  input  logic spi_cs_n,
  input  logic spi_mosi,
  output logic spi_miso,
  input  logic pwr_btn_n,
  input  logic acc_det_n,
  output logic irq
);
  logic               sclk_s, cs_n_s, mosi_s;
  logic               frame_done;
  logic [FRAME_W-1:0] frame_word;
  logic [ADDR_W-1:0]  rd_addr;
  logic [DATA_W-1:0]  rd_data;
  logic [DATA_W-1:0]  stat0, stat1, mask0, mask1;
  logic [1:0]         sense_lvl, sense_evt;
  logic               wr_en;
  logic               unused_bit24;

  pmic_sync #(.W(3), .STAGES(2), .RST_VAL(3'b010)) u_spi_sync (
    .clk(clk), .rst_n(rst_n),
    .d({spi_sclk, spi_cs_n, spi_mosi}),
    .q({sclk_s, cs_n_s, mosi_s})
  );

  pmic_spi_frame u_frame (
    .clk(clk), .rst_n(rst_n),
    .sclk_s(sclk_s), .cs_n_s(cs_n_s), .mosi_s(mosi_s),
    .rd_data(rd_data), .rd_addr(rd_addr),
    .frame_done(frame_done), .frame_word(frame_word),
    .miso(spi_miso)
  );

  pmic_sense #(.N(2)) u_sense (
    .clk(clk), .rst_n(rst_n),
    .raw_n({acc_det_n, pwr_btn_n}),
    .lvl(sense_lvl), .evt(sense_evt)
  );

  assign wr_en        = frame_done & fr_is_write(frame_word);
  assign unused_bit24 = frame_word[24];

  pmic_regbank #(.NUM_REGS(NUM_REGS)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(fr_addr(frame_word)), .wr_data(fr_data(frame_word)),
    .rd_addr(rd_addr), .sense_lvl(sense_lvl), .sense_evt(sense_evt),
    .rd_data(rd_data),
    .stat0(stat0), .stat1(stat1), .mask0(mask0), .mask1(mask1),
    .irq(irq)
  );
endmodule

// File: rtl/pmic_spi_regs_chk.sv
module pmic_spi_regs_chk
  import pmic_pkg::*;
#(
  parameter int NUM_REGS = 64
) (
  input logic               clk,
  input logic               rst_n,
  input logic               frame_done,
  input logic [FRAME_W-1:0] frame_word,
  input logic [DATA_W-1:0]  stat0,
  input logic [DATA_W-1:0]  stat1,
  input logic [DATA_W-1:0]  mask0,
  input logic [DATA_W-1:0]  mask1,
  input logic [1:0]         sense_evt,
  input logic               irq
);
  localparam logic [ADDR_W:0] NREG = (ADDR_W+1)'(NUM_REGS);

  p_evt_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sense_evt[0] |=> stat1[0]);

  p_evt_acc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sense_evt[1] |=> stat1[1]);

  p_w1c_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && frame_word[31] && frame_word[30:25] == A_STAT1 && sense_evt == 2'b00)
    |=> ((stat1 & $past(frame_word[23:0])) == '0));

  p_stat1_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_done && sense_evt == 2'b00) |=> $stable(stat1));

  p_stat0_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_done |=> $stable(stat0));

  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask0 == ALL_ONES && mask1 == ALL_ONES) |-> !irq);

  p_unmasked_irq_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat1 & ~mask1) != '0) |-> irq);

  p_read_no_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !frame_word[31]) |=> ($stable(mask0) && $stable(mask1)));

  p_reject_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && ({1'b0, frame_word[30:25]} >= NREG)) |=> ($stable(mask0) && $stable(mask1)));

  p_done_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind pmic_spi_regs pmic_spi_regs_chk #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n),
  .frame_done(frame_done), .frame_word(frame_word),
  .stat0(stat0), .stat1(stat1), .mask0(mask0), .mask1(mask1),
  .sense_evt(sense_evt), .irq(irq)
);

// File: tb/tb_pmic_spi_regs.sv
module tb_pmic_spi_regs;
  localparam int NREGS = 48;
  localparam int HP    = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, irq;
  logic pwr_n = 1'b1, acc_n = 1'b1;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  logic [31:0] r;
  logic [23:0] d;

  always #2.5 clk = ~clk;

  pmic_spi_regs #(.NUM_REGS(NREGS)) dut (
    .clk(clk), .rst_n(rst_n),
    .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_miso(miso),
    .pwr_btn_n(pwr_n), .acc_det_n(acc_n), .irq(irq)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cs_on();
    cs_n = 1'b0; tick(HP);
  endtask

  task automatic cs_off();
    tick(HP); cs_n = 1'b1; tick(2*HP);
  endtask

  task automatic xfer(input logic [31:0] w, output logic [31:0] rv);
    for (int i = 31; i >= 0; i--) begin
      mosi = w[i];
      tick(HP);
      rv[i] = miso;
      sclk = 1'b1;
      tick(HP);
      sclk = 1'b0;
    end
  endtask

  function automatic logic [31:0] wr_word(input int a, input logic [23:0] v);
    return {1'b1, 6'(a), 1'b0, v};
  endfunction

  function automatic logic [31:0] rd_word(input int a);
    return {1'b0, 6'(a), 25'b0};
  endfunction

  function automatic logic [23:0] pat(input int a);
    return (24'(a) * 24'h01F3A7) ^ 24'h5A3C96;
  endfunction

  // expected read value after the sweep, sense idle (both inputs high)
  function automatic logic [23:0] exp_after_sweep(input int a);
    if (a >= NREGS) return 24'h0;
    if (a == 0 || a == 2) return 24'h0;
    if (a == 4) return 24'h000003;
    return pat(a);
  endfunction

  task automatic wr(input int a, input logic [23:0] v);
    logic [31:0] dummy;
    cs_on(); xfer(wr_word(a, v), dummy); cs_off();
  endtask

  task automatic rd(input int a, output logic [23:0] v);
    logic [31:0] rv;
    cs_on(); xfer(rd_word(a), rv); cs_off();
    v = rv[23:0];
  endtask

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick(4);

    // reset state
    check(irq == 1'b0, "R6 irq after reset", {31'b0, irq}, 32'h0);
    rd(1, d); check(d == 24'hFFFFFF, "R6 mask0 reset", {8'h0, d}, 32'h00FFFFFF);
    rd(3, d); check(d == 24'hFFFFFF, "R6 mask1 reset", {8'h0, d}, 32'h00FFFFFF);
    rd(2, d); check(d == 24'h0, "R7 stat1 reset", {8'h0, d}, 32'h0);
    rd(4, d); check(d == 24'h3, "R8 sense idle", {8'h0, d}, 32'h3);
    rd(9, d); check(d == 24'h0, "R5 storage reset", {8'h0, d}, 32'h0);

    // sweep: stream writes to all 64 addresses in one transaction
    cs_on();
    for (int a = 0; a < 64; a++) xfer(wr_word(a, pat(a)), r);
    cs_off();
    // stream reads of all 64 addresses in one transaction
    cs_on();
    for (int a = 0; a < 64; a++) begin
      xfer(rd_word(a), r);
      if (a >= NREGS)
        check(r == {8'h0, exp_after_sweep(a)}, "R4 high address read", r, {8'h0, exp_after_sweep(a)});
      else if (a == 0 || a == 2)
        check(r == {8'h0, exp_after_sweep(a)}, "R7 status after ones", r, {8'h0, exp_after_sweep(a)});
      else if (a == 4)
        check(r == {8'h0, exp_after_sweep(a)}, "R8 sense write ignored", r, {8'h0, exp_after_sweep(a)});
      else
        check(r == {8'h0, exp_after_sweep(a)}, "R2 R3 R5 streamed readback", r, {8'h0, exp_after_sweep(a)});
    end
    cs_off();

    // restore masks
    wr(1, 24'hFFFFFF); wr(3, 24'hFFFFFF);

    // R1: bit 24 is ignored, data still lands
    cs_on(); xfer({1'b1, 6'd11, 1'b1, 24'h123456}, r); cs_off();
    rd(11, d); check(d == 24'h123456, "R1 bit 24 ignored", {8'h0, d}, 32'h00123456);

    // R11: truncated write frame is dropped
    cs_on();
    for (int i = 31; i >= 12; i--) begin
      mosi = wr_word(12, 24'hABCDEF)[i];
      tick(HP); sclk = 1'b1; tick(HP); sclk = 1'b0;
    end
    cs_off();
    rd(12, d); check(d == pat(12), "R11 cut frame discarded", {8'h0, d}, {8'h0, pat(12)});

    // R9/R8: power button press
    pwr_n = 1'b0; tick(10);
    rd(4, d); check(d == 24'h2, "R8 sense power active", {8'h0, d}, 32'h2);
    rd(2, d); check(d == 24'h1, "R9 power edge latched", {8'h0, d}, 32'h1);
    check(irq == 1'b0, "R6 masked event quiet", {31'b0, irq}, 32'h0);
    wr(3, 24'hFFFFFE); tick(2);
    check(irq == 1'b1, "R10 unmasked event raises irq", {31'b0, irq}, 32'h1);
    wr(2, 24'h000000);
    rd(2, d); check(d == 24'h1, "R7 zero write keeps bit", {8'h0, d}, 32'h1);
    wr(2, 24'h000001); tick(2);
    rd(2, d); check(d == 24'h0, "R7 one write clears bit", {8'h0, d}, 32'h0);
    check(irq == 1'b0, "R10 irq drops after clear", {31'b0, irq}, 32'h0);

    // release also counts as a change
    pwr_n = 1'b1; tick(10);
    check(irq == 1'b1, "R9 release edge raises irq", {31'b0, irq}, 32'h1);
    wr(3, 24'hFFFFFF); tick(2);
    check(irq == 1'b0, "R6 all-ones mask silences", {31'b0, irq}, 32'h0);
    wr(2, 24'hFFFFFF);

    // accessory detect: pulse low then high -> bit 1
    acc_n = 1'b0; tick(10);
    rd(4, d); check(d == 24'h1, "R8 sense accessory active", {8'h0, d}, 32'h1);
    acc_n = 1'b1; tick(10);
    rd(2, d); check(d == 24'h2, "R9 accessory edge latched", {8'h0, d}, 32'h2);
    wr(3, 24'hFFFFFE); tick(2);
    check(irq == 1'b0, "R10 other bit still masked", {31'b0, irq}, 32'h0);
    wr(3, 24'h000000); tick(2);
    check(irq == 1'b1, "R10 accessory unmasked", {31'b0, irq}, 32'h1);
    wr(0, 24'hFFFFFF);
    rd(0, d); check(d == 24'h0, "R7 status0 no source", {8'h0, d}, 32'h0);
    wr(1, 24'h000000); tick(2);
    check(irq == 1'b1, "R10 status0 empty keeps irq from status1", {31'b0, irq}, 32'h1);
    wr(2, 24'h000002); tick(2);
    check(irq == 1'b0, "R10 all clear", {31'b0, irq}, 32'h0);

    // R4: high-address write does not alias onto a low register
    wr(NREGS + 1, 24'h777777);
    rd(1, d); check(d == 24'h0, "R4 rejected write no alias", {8'h0, d}, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual %h expected %h", 32'h1, 32'h0);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule